// File: doc/BRIEF.md
# Nickel-Cell Charge Sequencer

This block sequences one charge cycle for a nickel-chemistry battery pack. It reads digitized comparator flags: cell above the maximum-cell threshold, cell below the low threshold, and pack too hot. It also reads an inhibit level, a supply-applied pulse, and two termination pulses from a separate slope detector (peak voltage and negative delta). From these it chooses one of three phases: pending, fast and complete.

It drives three outputs. The first is a charge-enable level for the external current switch, where high means current flows. The second is a flag that is high while that enable is being pulse-trickle modulated. The third is an LED drive, which is steadily lit in fast charge, blinks while pending, and is dark when complete.

A cycle starts when power comes up, when a supply-applied pulse arrives, or when the over-maximum flag falls, which is how a replaced battery is detected. The fast-charge safety limit and the trickle pulse width both follow a 2-bit mode input. Counter lengths are parameters. The small defaults suit simulation; a real chip scales them to minutes and milliseconds.

Top module: `nimh_charge_ctrl`

## Requirements
- R1: While reset is held, `trickle` is 1, `led` is 0 and `chg_en` is 1. Leaving reset counts as a new cycle, so with valid inputs `trickle` is 0 after the first clock edge.
- R2: Inputs are valid when `v_over_max`, `v_under_min` and `temp_hot` are all 0. Fast charge is entered only from valid inputs. From pending it is entered on the first edge at which the inputs are valid.
- R3: Whenever `v_over_max` is 1 at a clock edge, the block is in the complete phase after that edge, from any phase. In that phase `led` is 0 and `trickle` is 1.
- R4: A new cycle is either a `power_on` pulse or `v_over_max` going from 1 to 0 between two edges. It moves the block to fast charge with a cleared timer if the inputs are valid, and to pending if they are not.
- R5: In pending, `trickle` is 1 and `led` is a square wave that is high for FLASH_HALF cycles and low for FLASH_HALF cycles.
- R6: While `inhibit` is 1 in fast charge, `chg_en` is 0, the phase stays fast, the safety timer holds, and `term_pvd`/`term_ndv` are ignored. When `inhibit` returns to 0, charging resumes with the remaining time.
- R7: In fast charge, a `term_pvd` or `term_ndv` pulse without inhibit ends fast charge, and so does `temp_hot` at any time. The block is complete after that edge.
- R8: Fast charge ends after TIMER_UNIT << mode clock edges spent in fast charge without inhibit. With mode 0 and the default of 16, `trickle` reads 0 for exactly 16 samples.
- R9: The complete phase persists while there is no new cycle, even when the inputs are valid.
- R10: In pending and complete, `chg_en` is high for TRK_STEP*(mode+1) cycles of every TRK_PERIOD cycles. With the defaults this is 2 of 32 for mode 0 and 8 of 32 for mode 3.
- R11: In fast charge, `trickle` is 0, `led` is 1, and `chg_en` equals the inverse of `inhibit`. A low cell flag (`v_under_min`) does not end fast charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Selects safety limit and trickle pulse width |
| power_on | input | 1 | Supply-applied pulse, starts a new cycle |
| v_over_max | input | 1 | Cell voltage at or above maximum-cell threshold |
| v_under_min | input | 1 | Cell voltage at or below low threshold |
| temp_hot | input | 1 | Pack temperature above the hot limit |
| inhibit | input | 1 | Suspends fast charge while high |
| term_pvd | input | 1 | Peak-voltage termination event |
| term_ndv | input | 1 | Negative-delta termination event |
| chg_en | output | 1 | High lets charge current flow |
| trickle | output | 1 | High while chg_en is pulse-trickle modulated |
| led | output | 1 | Status lamp drive |

## Verification
The hardest situation to reach is proving that the safety timer really holds during inhibit. Its count is not visible at the ports. The bench therefore restarts a cycle with a `power_on` pulse and counts the samples in which `trickle` stays low. It raises `inhibit` for ten edges partway through and expects the fast window to grow from 16 samples to exactly 26. Pending and complete both show `trickle` high, so the bench tells them apart by counting `led` highs over a full flash period.

// File: rtl/nimh_charge_ctrl.sv
module nimh_charge_ctrl #(
  parameter int TIMER_UNIT = 16,
  parameter int TRK_PERIOD = 32,
  parameter int TRK_STEP   = 2,
  parameter int FLASH_HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       power_on,
  input  logic       v_over_max,
  input  logic       v_under_min,
  input  logic       temp_hot,
  input  logic       inhibit,
  input  logic       term_pvd,
  input  logic       term_ndv,
  output logic       chg_en,
  output logic       trickle,
  output logic       led
);

  localparam int TW = $clog2(TIMER_UNIT * 8) + 1;
  localparam int CW = $clog2(TRK_PERIOD + 1);
  localparam int FW = $clog2(FLASH_HALF + 1);

  typedef enum logic [1:0] {S_PEND, S_FAST, S_DONE} st_t;

  st_t           st, st_d;
  logic [TW-1:0] tmr;
  logic [TW-1:0] lim;
  logic [CW-1:0] tcnt;
  logic [FW-1:0] fcnt;
  logic [CW+1:0] pw;
  logic          flash;
  logic          ovm_q;

  wire valid   = ~v_over_max & ~v_under_min & ~temp_hot;
  wire new_cyc = power_on | (ovm_q & ~v_over_max);
  wire run     = (st == S_FAST) && !inhibit;
  wire tmo     = run && (tmr == lim - 1'b1);

  assign lim = TW'(TIMER_UNIT) << mode;
  assign pw  = (CW+2)'(TRK_STEP * (int'(mode) + 1));

  always_comb begin
    st_d = st;
    if (v_over_max)
      st_d = S_DONE;
    else if (new_cyc)
      st_d = valid ? S_FAST : S_PEND;
    else
      case (st)
        S_PEND:  if (valid) st_d = S_FAST;
        S_FAST:  if (temp_hot || (run && (term_pvd || term_ndv)) || tmo) st_d = S_DONE;
        default: st_d = st;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PEND;
      tmr   <= '0;
      ovm_q <= 1'b0;
    end else begin
      st    <= st_d;
      ovm_q <= v_over_max;
      if (st_d == S_FAST && (st != S_FAST || new_cyc))
        tmr <= '0;
      else if (run)
        tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      fcnt  <= '0;
      flash <= 1'b0;
    end else begin
      tcnt <= (tcnt == CW'(TRK_PERIOD - 1)) ? '0 : tcnt + 1'b1;
      if (fcnt == FW'(FLASH_HALF - 1)) begin
        fcnt  <= '0;
        flash <= ~flash;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign trickle = (st != S_FAST);
  assign chg_en  = trickle ? ((CW+2)'(tcnt) < pw) : ~inhibit;
  assign led     = (st == S_FAST) ? 1'b1 : (st == S_PEND) ? flash : 1'b0;

  assert_overmax_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v_over_max |=> st == S_DONE);

  assert_fast_entry_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAST && $past(st) != S_FAST) |-> $past(valid));

  assert_inhibit_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAST && inhibit && !v_over_max && !temp_hot && !new_cyc)
      |=> (st == S_FAST && tmr == $past(tmr)));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !new_cyc) |=> st == S_DONE);

  assert_timer_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_d == S_FAST && !new_cyc) |=> tmr == $past(tmr) + 1'b1);

endmodule

// File: tb/sim_nimh_charge_ctrl.sv
`timescale 1ns/1ps
module sim_nimh_charge_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       po = 1'b0, ovm = 1'b0, umin = 1'b0, hot = 1'b0, inh = 1'b0, pvd = 1'b0, ndv = 1'b0;
  logic       chg_en, trickle, led;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  nimh_charge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .power_on(po), .v_over_max(ovm),
    .v_under_min(umin), .temp_hot(hot), .inhibit(inh), .term_pvd(pvd),
    .term_ndv(ndv), .chg_en(chg_en), .trickle(trickle), .led(led)
  );

  // {po, ovm, umin, hot, inh, pvd, ndv, phase}  phase: 0 pending, 1 fast, 2 complete
  localparam logic [8:0] VEC [21] = '{
    9'b0_0_0_0_0_0_0_01,  // R11 fast after reset
    9'b0_0_0_0_1_0_0_01,  // R6 inhibit holds fast, chg_en low
    9'b0_0_1_0_0_0_0_01,  // R11 low cell ignored in fast
    9'b0_0_0_0_1_1_0_01,  // R6 pvd ignored while inhibited
    9'b0_0_0_0_0_1_0_10,  // R7 pvd ends fast
    9'b0_0_0_0_0_0_0_10,  // R9 complete sticky
    9'b1_0_0_1_0_0_0_00,  // R4 power pulse, hot -> pending (R5)
    9'b0_0_0_0_0_0_0_01,  // R2 pending -> fast once valid
    9'b0_0_0_0_0_0_1_10,  // R7 ndv ends fast
    9'b0_1_0_0_0_0_0_10,  // R3 over max
    9'b0_0_0_1_0_0_0_00,  // R4 fall through max, hot -> pending
    9'b0_0_0_0_0_0_0_01,  // R2
    9'b0_0_0_1_0_0_0_10,  // R7 hot ends fast
    9'b0_0_0_0_0_0_0_10,  // R9
    9'b0_1_0_0_0_0_0_10,  // R3
    9'b0_0_0_0_0_0_0_01,  // R4 battery replaced, valid -> fast
    9'b0_1_0_0_0_0_0_10,  // R3 over max during fast
    9'b0_0_1_0_0_0_0_00,  // R4 fall with low cell -> pending
    9'b0_1_0_0_0_0_0_10,  // R3 over max from pending
    9'b0_0_0_0_0_0_0_01,  // R4
    9'b1_0_0_0_0_0_0_01   // R4 power pulse during fast stays fast
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input int idx, input logic [1:0] ph);
    int highs = 0, trks = 0, bad = 0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      highs += int'(led);
      trks  += int'(trickle);
      if (ph == 2'd1 && chg_en != ~inh) bad++;
    end
    case (ph)
      2'd1: chk(highs == 16 && trks == 0 && bad == 0,
                $sformatf("R11 vec %0d fast", idx), highs*100 + trks + bad*10000, 1600);
      2'd2: chk(highs == 0 && trks == 16,
                $sformatf("R3 vec %0d complete", idx), highs*100 + trks, 16);
      default: chk(highs == 8 && trks == 16,
                $sformatf("R5 vec %0d pending", idx), highs*100 + trks, 816);
    endcase
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt, highs;
    repeat (3) @(negedge clk);
    chk(trickle == 1'b1 && led == 1'b0 && chg_en == 1'b1, "R1 reset outputs",
        {trickle, led, chg_en}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trickle == 1'b0, "R1 fast after reset", trickle, 0);

    for (int i = 0; i < 21; i++) begin
      {po, ovm, umin, hot, inh, pvd, ndv} = VEC[i][8:2];
      @(negedge clk);
      po = 1'b0;
      observe(i, VEC[i][1:0]);
    end

    // R10 trickle duty in complete phase
    ovm = 1'b1; umin = 1'b0; hot = 1'b0; inh = 1'b0; pvd = 1'b0; ndv = 1'b0;
    mode = 2'd0;
    @(negedge clk);
    highs = 0;
    for (int k = 0; k < 32; k++) begin @(negedge clk); highs += int'(chg_en); end
    chk(highs == 2, "R10 duty mode 0", highs, 2);
    mode = 2'd3;
    @(negedge clk);
    highs = 0;
    for (int k = 0; k < 32; k++) begin @(negedge clk); highs += int'(chg_en); end
    chk(highs == 8, "R10 duty mode 3", highs, 8);

    // R8 safety timer, mode 0
    mode = 2'd0;
    ovm = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      if (trickle) break;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 16, "R8 timer length", cnt, 16);

    // R9 stays complete after timeout with valid inputs
    highs = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); highs += int'(trickle) + int'(led); end
    chk(highs == 40, "R9 sticky after timeout", highs, 40);

    // R6 timer holds during inhibit
    po = 1'b1;
    @(negedge clk);
    po = 1'b0;
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      if (trickle) break;
      cnt++;
      if (cnt == 5) inh = 1'b1;
      if (cnt == 15) inh = 1'b0;
      @(negedge clk);
    end
    chk(cnt == 26, "R6 inhibit extends fast window", cnt, 26);
    chk(led == 1'b0, "R8 complete after timer", led, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule